// File: doc/BRIEF.md
# Color-Locked Timing Generator

This block produces every timing strobe for a retro home-computer core from one master clock of 14.31818 MHz, which is four times the 3.579545 MHz colorburst. It makes no derived clocks. It drives one-cycle enable pulses, and the downstream logic runs on the master clock and acts only on those pulses. Each processor cycle normally spans 14 master clocks. The first half of the cycle is the memory slot for the video fetch and the second half is the slot for the processor. A processor enable marks the last master clock of each cycle.

A scan line holds 65 processor cycles. The final cycle of each line is stretched by two master clocks, which gives 912 master clocks per line. That is exactly 228 colorburst periods, so the colorburst phase at the start of every line is the same. A horizontal counter advances once per processor cycle. A vertical counter advances once per line and wraps at the end of the frame, where it pulses a frame-start strobe. The video fetch logic uses these counters and the colorburst phase. The block has no data stream and therefore no valid/ready interface. All pins are plain control pins.

Top module: `color_timing_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the next state has `cyc_phase`, `hcount`, `vcount` and `burst_phase` all zero. In that same state `line_start` and `frame_start` are both 1.
- R2: Every processor cycle except the last of a line lasts 14 master clocks. `cyc_phase` counts 0 to 13 in it.
- R3: The last cycle of a line (`hcount` = 64) lasts 16 master clocks. `cyc_phase` counts 0 to 15 in it, and `long_cycle` is 1 for exactly that cycle.
- R4: `hcount` counts 0 to 64, one step per processor cycle, and returns to 0 after 64. A line is 912 master clocks.
- R5: `burst_phase` advances by 1 modulo 4 on every master clock and is 0 whenever `line_start` is 1.
- R6: `mem_owner_vid` is 1 (video owns memory) for `cyc_phase` 0 to 6 and 0 (processor owns memory) for every later phase of the cycle.
- R7: `cpu_en` is 1 only on the final master clock of each processor cycle (phase 13, or phase 15 in the stretched cycle). `vid_en` is 1 only on phase 6, the last clock of the video slot.
- R8: `vcount` counts 0 to LINES_PER_FRAME-1 (default 262 lines), one step after each line, and wraps to 0. `line_start` is 1 on phase 0 of cycle 0 of each line. `frame_start` is 1 only on that clock of line 0.
- R9: A reset asserted in the middle of a frame puts all counters back to line 0, cycle 0, phase 0 on the next clock. Counting then resumes from there.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Master clock, 14.31818 MHz |
| rst | input | 1 | Synchronous reset, active high |
| cpu_en | output | 1 | One-clock processor enable at the end of each cycle |
| vid_en | output | 1 | One-clock enable at the end of the video slot |
| mem_owner_vid | output | 1 | 1 when the video owns memory, 0 when the processor owns it |
| long_cycle | output | 1 | High during the stretched last cycle of a line |
| cyc_phase | output | 4 | Master-clock position within the processor cycle |
| hcount | output | 7 | Processor cycle within the line, 0 to 64 |
| vcount | output | 9 | Line within the frame |
| burst_phase | output | 2 | Colorburst quarter-period phase |
| line_start | output | 1 | First master clock of each line |
| frame_start | output | 1 | First master clock of each frame |

## Verification
Every output is a decode of a few registers, so a wrong internal state shows at the ports on the very clock it occurs. If the phase counter goes off by one, `cpu_en` and `mem_owner_vid` move within one processor cycle. If the stretch is missing or misplaced, `burst_phase` is no longer 0 at `line_start` by the end of the first line, after 912 clocks. If a vertical wrap is wrong, it shows as a missing or extra `frame_start` at the first frame boundary. The bench compares every output on every clock against a model that derives all values from the count of master clocks since reset. It runs with a short frame so that several vertical wraps are covered.

// File: rtl/tg_pkg.sv
package tg_pkg;
  typedef enum logic {
    OWN_CPU   = 1'b0,
    OWN_VIDEO = 1'b1
  } mem_owner_e;
endpackage

// File: rtl/tg_cycle_ctr.sv
module tg_cycle_ctr #(
  parameter int BASE  = 14,
  parameter int EXTRA = 2,
  parameter int W     = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         extend,
  output logic [W-1:0] phase,
  output logic         last
);
  localparam logic [W-1:0] SHORT_END = W'(BASE - 1);
  localparam logic [W-1:0] LONG_END  = W'(BASE + EXTRA - 1);

  assign last = (phase == (extend ? LONG_END : SHORT_END));

  always_ff @(posedge clk) begin
    if (rst)       phase <= '0;
    else if (last) phase <= '0;
    else           phase <= phase + 1'b1;
  end
endmodule

// File: rtl/tg_wrap_ctr.sv
module tg_wrap_ctr #(
  parameter int MOD = 65,
  parameter int W   = 7
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  output logic [W-1:0] count,
  output logic         at_last
);
  localparam logic [W-1:0] TOP = W'(MOD - 1);

  assign at_last = (count == TOP);

  always_ff @(posedge clk) begin
    if (rst)      count <= '0;
    else if (adv) count <= at_last ? '0 : count + 1'b1;
  end
endmodule

// File: rtl/tg_burst_ctr.sv
module tg_burst_ctr #(
  parameter int DIV = 4,
  parameter int W   = 2
) (
  input  logic         clk,
  input  logic         rst,
  output logic [W-1:0] phase
);
  localparam logic [W-1:0] TOP = W'(DIV - 1);

  always_ff @(posedge clk) begin
    if (rst)               phase <= '0;
    else if (phase == TOP) phase <= '0;
    else                   phase <= phase + 1'b1;
  end
endmodule

// File: rtl/color_timing_gen.sv
module color_timing_gen #(
  parameter int SUB_CLKS        = 14,
  parameter int STRETCH_CLKS    = 2,
  parameter int CYCLES_PER_LINE = 65,
  parameter int LINES_PER_FRAME = 262,
  parameter int BURST_DIV       = 4,
  localparam int PW = $clog2(SUB_CLKS + STRETCH_CLKS),
  localparam int HW = $clog2(CYCLES_PER_LINE),
  localparam int VW = $clog2(LINES_PER_FRAME),
  localparam int BW = $clog2(BURST_DIV)
) (
  input  logic          clk,
  input  logic          rst,
  output logic          cpu_en,
  output logic          vid_en,
  output logic          mem_owner_vid,
  output logic          long_cycle,
  output logic [PW-1:0] cyc_phase,
  output logic [HW-1:0] hcount,
  output logic [VW-1:0] vcount,
  output logic [BW-1:0] burst_phase,
  output logic          line_start,
  output logic          frame_start
);
  import tg_pkg::*;

  localparam int HALF = SUB_CLKS / 2;

  logic       cyc_last;
  logic       h_last;
  logic       v_last;
  mem_owner_e owner;

  // Phase within a processor cycle; stretched while on the last cycle of the line
  tg_cycle_ctr #(.BASE(SUB_CLKS), .EXTRA(STRETCH_CLKS), .W(PW)) u_cycle (
    .clk(clk), .rst(rst), .extend(h_last), .phase(cyc_phase), .last(cyc_last)
  );

  tg_wrap_ctr #(.MOD(CYCLES_PER_LINE), .W(HW)) u_horiz (
    .clk(clk), .rst(rst), .adv(cyc_last), .count(hcount), .at_last(h_last)
  );

  tg_wrap_ctr #(.MOD(LINES_PER_FRAME), .W(VW)) u_vert (
    .clk(clk), .rst(rst), .adv(cyc_last & h_last), .count(vcount), .at_last(v_last)
  );

  tg_burst_ctr #(.DIV(BURST_DIV), .W(BW)) u_burst (
    .clk(clk), .rst(rst), .phase(burst_phase)
  );

  always_comb owner = (cyc_phase < PW'(HALF)) ? OWN_VIDEO : OWN_CPU;

  assign mem_owner_vid = (owner == OWN_VIDEO);
  assign cpu_en        = cyc_last;
  assign vid_en        = (cyc_phase == PW'(HALF - 1));
  assign long_cycle    = h_last;
  assign line_start    = (hcount == '0) && (cyc_phase == '0);
  assign frame_start   = line_start && (vcount == '0);

  logic unused_v_last;
  assign unused_v_last = v_last;
endmodule

// File: rtl/tg_checker.sv
module tg_checker #(
  parameter int SUB_CLKS        = 14,
  parameter int STRETCH_CLKS    = 2,
  parameter int CYCLES_PER_LINE = 65,
  parameter int LINES_PER_FRAME = 262,
  parameter int BURST_DIV       = 4,
  localparam int PW = $clog2(SUB_CLKS + STRETCH_CLKS),
  localparam int HW = $clog2(CYCLES_PER_LINE),
  localparam int VW = $clog2(LINES_PER_FRAME),
  localparam int BW = $clog2(BURST_DIV)
) (
  input logic          clk,
  input logic          rst,
  input logic          cpu_en,
  input logic          vid_en,
  input logic          mem_owner_vid,
  input logic          long_cycle,
  input logic [PW-1:0] cyc_phase,
  input logic [HW-1:0] hcount,
  input logic [VW-1:0] vcount,
  input logic [BW-1:0] burst_phase,
  input logic          line_start,
  input logic          frame_start
);
  localparam logic [HW-1:0] H_END = HW'(CYCLES_PER_LINE - 1);
  localparam logic [VW-1:0] V_END = VW'(LINES_PER_FRAME - 1);
  localparam logic [BW-1:0] B_END = BW'(BURST_DIV - 1);
  localparam logic [PW-1:0] L_END = PW'(SUB_CLKS + STRETCH_CLKS - 1);
  localparam logic [PW-1:0] S_END = PW'(SUB_CLKS - 1);

  p_reset_state_r1: assert property (@(posedge clk)
    rst |=> (hcount == '0 && vcount == '0 && cyc_phase == '0 && frame_start));

  p_short_end_r2: assert property (@(posedge clk) disable iff (rst)
    (cpu_en && !long_cycle) |-> cyc_phase == S_END);

  p_long_end_r3: assert property (@(posedge clk) disable iff (rst)
    (cpu_en && long_cycle) |-> cyc_phase == L_END);

  p_long_pos_r3: assert property (@(posedge clk) disable iff (rst)
    long_cycle |-> hcount == H_END);

  p_hadv_r4: assert property (@(posedge clk) disable iff (rst)
    (cpu_en && !long_cycle) |=> hcount == HW'($past(hcount) + 1'b1));

  p_hwrap_r4: assert property (@(posedge clk) disable iff (rst)
    (cpu_en && long_cycle) |=> (hcount == '0 && line_start));

  p_burst_step_r5: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> burst_phase == (($past(burst_phase) == B_END) ? '0 : BW'($past(burst_phase) + 1'b1)));

  p_burst_lock_r5: assert property (@(posedge clk) disable iff (rst)
    line_start |-> burst_phase == '0);

  p_owner_cpu_r6: assert property (@(posedge clk) disable iff (rst)
    cpu_en |-> !mem_owner_vid);

  p_owner_vid_r6: assert property (@(posedge clk) disable iff (rst)
    vid_en |-> mem_owner_vid);

  p_strobes_r7: assert property (@(posedge clk) disable iff (rst)
    cpu_en |=> (cyc_phase == '0 && !cpu_en));

  p_vwrap_r8: assert property (@(posedge clk) disable iff (rst)
    (cpu_en && long_cycle && vcount == V_END) |=> (vcount == '0 && frame_start));

  p_frame_r8: assert property (@(posedge clk) disable iff (rst)
    frame_start |-> (line_start && vcount == '0));
endmodule

bind color_timing_gen tg_checker #(
  .SUB_CLKS(SUB_CLKS), .STRETCH_CLKS(STRETCH_CLKS), .CYCLES_PER_LINE(CYCLES_PER_LINE),
  .LINES_PER_FRAME(LINES_PER_FRAME), .BURST_DIV(BURST_DIV)
) u_chk (
  .clk(clk), .rst(rst), .cpu_en(cpu_en), .vid_en(vid_en), .mem_owner_vid(mem_owner_vid),
  .long_cycle(long_cycle), .cyc_phase(cyc_phase), .hcount(hcount), .vcount(vcount),
  .burst_phase(burst_phase), .line_start(line_start), .frame_start(frame_start)
);

// File: tb/color_timing_gen_bench.sv
module color_timing_gen_bench;
  localparam int LINES = 8;
  localparam int LINE_CLKS = 912;
  localparam int FRAME_CLKS = LINE_CLKS * LINES;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpu_en, vid_en, mem_owner_vid, long_cycle, line_start, frame_start;
  logic [3:0] cyc_phase;
  logic [6:0] hcount;
  logic [2:0] vcount;
  logic [1:0] burst_phase;

  int tests = 0;
  int fails = 0;
  int t = 0;
  bit started = 0;
  bit done = 0;
  int clk_cnt = 0;
  int last_en = -1;

  always #10 clk = ~clk;

  color_timing_gen #(.LINES_PER_FRAME(LINES)) u_color_timing_gen (
    .clk(clk), .rst(rst), .cpu_en(cpu_en), .vid_en(vid_en), .mem_owner_vid(mem_owner_vid),
    .long_cycle(long_cycle), .cyc_phase(cyc_phase), .hcount(hcount), .vcount(vcount),
    .burst_phase(burst_phase), .line_start(line_start), .frame_start(frame_start)
  );

  task automatic check(input string req, input string what, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d at clock %0d", req, what, act, exp, clk_cnt);
    end
  endtask

  // Reference: every output is a function of master clocks since reset
  always @(posedge clk) begin
    clk_cnt++;
    if (rst) begin
      t = 0;
      last_en = -1;
    end else t = t + 1;
    started = 1;
  end

  always @(negedge clk) begin
    if (started && !done) begin
      int pos;
      int ph;
      int h;
      bit lng;
      pos = t % LINE_CLKS;
      lng = (pos >= 64 * 14);
      h   = lng ? 64 : pos / 14;
      ph  = lng ? pos - 64 * 14 : pos % 14;
      check("R2", "cyc_phase", cyc_phase, ph);
      check("R3", "long_cycle", long_cycle, lng);
      check("R4", "hcount", hcount, h);
      check("R5", "burst_phase", burst_phase, t % 4);
      check("R6", "mem_owner_vid", mem_owner_vid, ph < 7);
      check("R7", "cpu_en", cpu_en, lng ? (ph == 15) : (ph == 13));
      check("R7", "vid_en", vid_en, ph == 6);
      check("R8", "vcount", vcount, (t / LINE_CLKS) % LINES);
      check("R8", "line_start", line_start, pos == 0);
      check("R8", "frame_start", frame_start, (t % FRAME_CLKS) == 0);
      if (cpu_en) begin
        if (last_en >= 0)
          check(long_cycle ? "R3" : "R2", "cycle length", t - last_en, long_cycle ? 16 : 14);
        last_en = t;
      end
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #5;
    check("R1", "hcount after reset", hcount, 0);
    check("R1", "vcount after reset", vcount, 0);
    check("R1", "frame_start after reset", frame_start, 1);
    rst = 1'b0;
    repeat (3 * FRAME_CLKS + 1234) @(posedge clk);
    #5 rst = 1'b1;
    @(posedge clk);
    #5;
    check("R9", "cyc_phase after mid-frame reset", cyc_phase, 0);
    check("R9", "hcount after mid-frame reset", hcount, 0);
    check("R9", "vcount after mid-frame reset", vcount, 0);
    check("R9", "burst_phase after mid-frame reset", burst_phase, 0);
    rst = 1'b0;
    repeat (2 * LINE_CLKS + 50) @(posedge clk);
    #5 finish_run();
  end

  initial begin
    #(20 * 100000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule